// File: doc/BRIEF.md
# Descriptor-Driven Multi-Channel DMA Engine

This block is a small DMA engine shared by a handful of channels. It keeps no per-channel transfer state in registers. Each channel owns a three-word control record in shared memory: source address, destination address and a control word. When a channel is serviced, the engine reads its record, moves data over a single memory master port, and writes the updated record back. Each channel has one hardware request line and one software start input. Peripherals use the request line for memory-to-peripheral and peripheral-to-memory traffic. Software uses the start input for memory-to-memory copies.

Pending channels are arbitrated by fixed priority. The channel being serviced is shown on an active-channel output. A slow peripheral can hold off the end of a service cycle with a stall input, and the engine does not close a cycle while that channel's request is still high. A channel gets a one-cycle done pulse when its element count reaches zero. A bus error response, or a control word with illegal sizes, raises a sticky error flag and halts the channel.

Top module: `dma_engine`

## Requirements
- R1: The control word holds the source size code in bits [1:0] and the destination size code in bits [3:2]. Code 0 is a byte, 1 a half-word and 2 a word. Element data travels in the low bits of memRdata and memWdata, and memSize carries the code during element accesses.
- R2: A control word whose two size codes differ, or which uses code 3, is rejected. busError is set, the channel halts, no element access is made and no write-back happens.
- R3: A channel's record sits at DESC_BASE + 16*channel, with the source address at +0, the destination address at +4 and the control word at +8. Every access to the record is made with memSize = 2 (word).
- R4: After a completed service cycle, the engine writes back the source address, the destination address and the control word. The remaining count in control bits [31:16] is reduced by the number of elements moved.
- R5: When several channels are pending in the same cycle, the lowest channel index is served first.
- R6: activeValid is high and activeCh holds the served channel from the first record read to the end of write-back. activeValid is low in reset and when idle.
- R7: chDone pulses for one cycle for a channel after its control word is written back with a remaining count of zero, and at no other time.
- R8: A memError response on an accepted access sets busError until reset, abandons the cycle without write-back, and halts the channel so that it ignores later starts.
- R9: While periphStall is high, a cycle whose elements have been moved does not begin write-back.
- R10: Write-back does not begin while the served channel's request line is high.
- R11: Control bits [11:8] hold a burst field B. Each request or start moves min(B+1, remaining count) elements.
- R12: A one-cycle chSwStart pulse is latched and starts a service cycle exactly as a request would, with no request line involved.
- R13: Control bit 4 enables source increment and bit 5 enables destination increment. An enabled address advances by the element size in bytes after each element; a disabled one stays fixed.
- R14: An access that is not yet accepted (memReady low) keeps memValid, memAddr and memWrite unchanged until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chReq | input | NUM_CH | Per-channel hardware request lines |
| chSwStart | input | NUM_CH | Per-channel software start pulses |
| periphStall | input | 1 | Holds off the end of the current service cycle |
| memValid | output | 1 | Memory access request |
| memWrite | output | 1 | 1 = write, 0 = read |
| memSize | output | 2 | Access size code (0 byte, 1 half, 2 word) |
| memAddr | output | 32 | Byte address |
| memWdata | output | 32 | Write data, element in low bits |
| memRdata | input | 32 | Read data, element in low bits |
| memReady | input | 1 | Access accepted this cycle |
| memError | input | 1 | Error response for the accepted access |
| activeCh | output | $clog2(NUM_CH) | Channel being served |
| activeValid | output | 1 | A channel is being served |
| chDone | output | NUM_CH | One-cycle completion pulse per channel |
| busError | output | 1 | Sticky error flag |

## Verification
Two things can land in the same cycle. One is arbitration among channels that become pending together: both software starts are pulsed on the same edge, and the bench checks that channel 0 is logged as active before channel 1 and that both copies arrive. The other is the end-of-cycle hold, where the request-release wait and the stall overlap. A request is dropped while periphStall is still high, and the bench checks that the stored control word keeps its old count until the stall is removed. Record write-back and bus wait states also meet: a random-free alternating ready pattern holds each access, and every held access is compared with the one that follows it.

// File: rtl/dma_pkg.sv
package dma_pkg;
  // control word field positions (decoded by the datapath, written by software)
  localparam int CTL_SRCSZ_LO = 0;
  localparam int CTL_DSTSZ_LO = 2;
  localparam int CTL_SRCINC   = 4;
  localparam int CTL_DSTINC   = 5;
  localparam int CTL_BURST_LO = 8;
  localparam int CTL_BURST_W  = 4;
  localparam int CTL_CNT_LO   = 16;
  localparam int CTL_CNT_W    = 16;
  localparam logic [1:0] SIZE_WORD = 2'd2;
  localparam logic [1:0] SIZE_BAD  = 2'd3;

  typedef enum logic [2:0] {
    SEL_DSRC, SEL_DDST, SEL_DCTL, SEL_SRC, SEL_DST
  } addrSel_t;

  typedef struct packed {
    addrSel_t addrSel;
    logic     ldWord;
    logic     ldData;
    logic     advance;
  } dpStrobe_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FSRC, ST_FDST, ST_FCTL, ST_CHECK, ST_RD, ST_WR,
    ST_HOLD, ST_WSRC, ST_WDST, ST_WCTL
  } dmaState_t;
endpackage

// File: rtl/dma_path.sv
module dma_path
  import dma_pkg::*;
#(
  parameter int          NUM_CH    = 2,
  parameter logic [31:0] DESC_BASE = 32'h0
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dpStrobe_t                 stb,
  input  logic [$clog2(NUM_CH)-1:0] chSel,
  input  logic [31:0]               memRdata,
  output logic [31:0]               memAddr,
  output logic [1:0]                memSize,
  output logic [31:0]               memWdata,
  output logic                      sizeOk,
  output logic                      countZero,
  output logic                      lastBeat
);
  localparam int BEAT_W = CTL_BURST_W + 1;

  logic [31:0] srcAddr, dstAddr, ctlWord, dataBuf;
  logic [BEAT_W-1:0] beatsLeft;
  logic [1:0] srcSz, dstSz;
  logic [CTL_CNT_W-1:0] count;
  logic [31:0] elemBytes, sizeMask, descBase;

  assign srcSz     = ctlWord[CTL_SRCSZ_LO +: 2];
  assign dstSz     = ctlWord[CTL_DSTSZ_LO +: 2];
  assign count     = ctlWord[CTL_CNT_LO +: CTL_CNT_W];
  assign elemBytes = 32'd1 << srcSz;
  assign descBase  = DESC_BASE + (32'(chSel) << 4);
  assign sizeOk    = (srcSz == dstSz) && (srcSz != SIZE_BAD);
  assign countZero = (count == '0);
  assign lastBeat  = (count == CTL_CNT_W'(1)) || (beatsLeft == BEAT_W'(1));

  always_comb begin
    unique case (srcSz)
      2'd0:    sizeMask = 32'h0000_00FF;
      2'd1:    sizeMask = 32'h0000_FFFF;
      default: sizeMask = 32'hFFFF_FFFF;
    endcase
  end

  // address, size and write data follow the access the control selects
  always_comb begin
    memSize  = SIZE_WORD;
    memAddr  = descBase;
    memWdata = srcAddr;
    unique case (stb.addrSel)
      SEL_DSRC: begin memAddr = descBase;          memWdata = srcAddr; end
      SEL_DDST: begin memAddr = descBase + 32'd4;  memWdata = dstAddr; end
      SEL_DCTL: begin memAddr = descBase + 32'd8;  memWdata = ctlWord; end
      SEL_SRC:  begin memAddr = srcAddr; memSize = srcSz; memWdata = dataBuf; end
      SEL_DST:  begin memAddr = dstAddr; memSize = dstSz; memWdata = dataBuf; end
      default:  begin memAddr = descBase; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcAddr   <= '0;
      dstAddr   <= '0;
      ctlWord   <= '0;
      dataBuf   <= '0;
      beatsLeft <= '0;
    end else begin
      if (stb.ldWord) begin
        unique case (stb.addrSel)
          SEL_DSRC: srcAddr <= memRdata;
          SEL_DDST: dstAddr <= memRdata;
          SEL_DCTL: begin
            ctlWord   <= memRdata;
            beatsLeft <= BEAT_W'(memRdata[CTL_BURST_LO +: CTL_BURST_W]) + BEAT_W'(1);
          end
          default: ;
        endcase
      end
      if (stb.ldData) dataBuf <= memRdata & sizeMask;
      if (stb.advance) begin
        if (ctlWord[CTL_SRCINC]) srcAddr <= srcAddr + elemBytes;
        if (ctlWord[CTL_DSTINC]) dstAddr <= dstAddr + elemBytes;
        ctlWord[CTL_CNT_LO +: CTL_CNT_W] <= count - CTL_CNT_W'(1);
        beatsLeft <= beatsLeft - BEAT_W'(1);
      end
    end
  end

  // R11: an element is only moved while count and burst allowance remain
  assert_count_left_R11: assert property (@(posedge clk) disable iff (!rstN)
    stb.advance |-> (!countZero && beatsLeft != '0));
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_CH-1:0]         chReq,
  input  logic [NUM_CH-1:0]         chSwStart,
  input  logic                      periphStall,
  input  logic                      memReady,
  input  logic                      memError,
  input  logic                      sizeOk,
  input  logic                      countZero,
  input  logic                      lastBeat,
  output dpStrobe_t                 stb,
  output logic                      memValid,
  output logic                      memWrite,
  output logic [$clog2(NUM_CH)-1:0] activeCh,
  output logic                      activeValid,
  output logic [NUM_CH-1:0]         chDone,
  output logic                      busError
);
  localparam int CH_W = $clog2(NUM_CH);

  dmaState_t state, nxt;
  logic [CH_W-1:0] curCh, grantIdx;
  logic [NUM_CH-1:0] swPend, halted, pend, grantMask, lowMask;
  logic anyPend, accOk, accErr, rejectNow;

  assign pend      = (chReq | swPend) & ~halted;
  assign anyPend   = |pend;
  assign grantMask = (state == ST_IDLE && anyPend) ? (NUM_CH'(1) << grantIdx) : '0;
  assign lowMask   = (NUM_CH'(1) << curCh) - NUM_CH'(1);
  assign accOk     = memValid && memReady && !memError;
  assign accErr    = memValid && memReady && memError;
  assign rejectNow = (state == ST_CHECK) && !sizeOk;
  assign activeCh  = curCh;
  assign activeValid = (state != ST_IDLE);

  // R5: fixed priority, lowest index wins
  always_comb begin
    grantIdx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--)
      if (pend[i]) grantIdx = CH_W'(i);
  end

  always_comb begin
    stb      = '{addrSel: SEL_DSRC, default: '0};
    memValid = 1'b0;
    memWrite = 1'b0;
    nxt      = state;
    unique case (state)
      ST_IDLE:  if (anyPend) nxt = ST_FSRC;
      ST_FSRC: begin
        memValid = 1'b1; stb.addrSel = SEL_DSRC;
        if (memReady) begin
          if (memError) nxt = ST_IDLE;
          else begin stb.ldWord = 1'b1; nxt = ST_FDST; end
        end
      end
      ST_FDST: begin
        memValid = 1'b1; stb.addrSel = SEL_DDST;
        if (memReady) begin
          if (memError) nxt = ST_IDLE;
          else begin stb.ldWord = 1'b1; nxt = ST_FCTL; end
        end
      end
      ST_FCTL: begin
        memValid = 1'b1; stb.addrSel = SEL_DCTL;
        if (memReady) begin
          if (memError) nxt = ST_IDLE;
          else begin stb.ldWord = 1'b1; nxt = ST_CHECK; end
        end
      end
      ST_CHECK: begin
        if (!sizeOk)        nxt = ST_IDLE;
        else if (countZero) nxt = ST_HOLD;
        else                nxt = ST_RD;
      end
      ST_RD: begin
        memValid = 1'b1; stb.addrSel = SEL_SRC;
        if (memReady) begin
          if (memError) nxt = ST_IDLE;
          else begin stb.ldData = 1'b1; nxt = ST_WR; end
        end
      end
      ST_WR: begin
        memValid = 1'b1; memWrite = 1'b1; stb.addrSel = SEL_DST;
        if (memReady) begin
          if (memError) nxt = ST_IDLE;
          else begin stb.advance = 1'b1; nxt = lastBeat ? ST_HOLD : ST_RD; end
        end
      end
      ST_HOLD:  if (!chReq[curCh] && !periphStall) nxt = ST_WSRC;
      ST_WSRC: begin
        memValid = 1'b1; memWrite = 1'b1; stb.addrSel = SEL_DSRC;
        if (memReady) nxt = memError ? ST_IDLE : ST_WDST;
      end
      ST_WDST: begin
        memValid = 1'b1; memWrite = 1'b1; stb.addrSel = SEL_DDST;
        if (memReady) nxt = memError ? ST_IDLE : ST_WCTL;
      end
      ST_WCTL: begin
        memValid = 1'b1; memWrite = 1'b1; stb.addrSel = SEL_DCTL;
        if (memReady) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      curCh    <= '0;
      swPend   <= '0;
      halted   <= '0;
      chDone   <= '0;
      busError <= 1'b0;
    end else begin
      state  <= nxt;
      swPend <= (swPend & ~grantMask) | chSwStart;
      if (state == ST_IDLE && anyPend) curCh <= grantIdx;
      if (accErr || rejectNow) begin
        busError      <= 1'b1;
        halted[curCh] <= 1'b1;
      end
      chDone <= '0;
      if (state == ST_WCTL && accOk && countZero) chDone[curCh] <= 1'b1;
    end
  end

  assert_lowest_first_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FSRC && $past(state) == ST_IDLE) |-> (($past(pend) & lowMask) == '0));
  assert_done_onehot_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chDone));
  assert_done_after_wb_R7: assert property (@(posedge clk) disable iff (!rstN)
    (|chDone) |-> ($past(state) == ST_WCTL));
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && periphStall) |=> (state == ST_HOLD));
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && chReq[curCh]) |=> (state == ST_HOLD));
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    busError |=> busError);
  assert_halted_skip_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FSRC && $past(state) == ST_IDLE) |-> !$past(halted[curCh]));
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int          NUM_CH    = 2,
  parameter logic [31:0] DESC_BASE = 32'h0
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_CH-1:0]         chReq,
  input  logic [NUM_CH-1:0]         chSwStart,
  input  logic                      periphStall,
  output logic                      memValid,
  output logic                      memWrite,
  output logic [1:0]                memSize,
  output logic [31:0]               memAddr,
  output logic [31:0]               memWdata,
  input  logic [31:0]               memRdata,
  input  logic                      memReady,
  input  logic                      memError,
  output logic [$clog2(NUM_CH)-1:0] activeCh,
  output logic                      activeValid,
  output logic [NUM_CH-1:0]         chDone,
  output logic                      busError
);
  dpStrobe_t stb;
  logic sizeOk, countZero, lastBeat;

  dma_ctrl #(.NUM_CH(NUM_CH)) uCtrl (
    .clk(clk), .rstN(rstN), .chReq(chReq), .chSwStart(chSwStart),
    .periphStall(periphStall), .memReady(memReady), .memError(memError),
    .sizeOk(sizeOk), .countZero(countZero), .lastBeat(lastBeat),
    .stb(stb), .memValid(memValid), .memWrite(memWrite),
    .activeCh(activeCh), .activeValid(activeValid), .chDone(chDone),
    .busError(busError)
  );

  dma_path #(.NUM_CH(NUM_CH), .DESC_BASE(DESC_BASE)) uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .chSel(activeCh),
    .memRdata(memRdata), .memAddr(memAddr), .memSize(memSize),
    .memWdata(memWdata), .sizeOk(sizeOk), .countZero(countZero),
    .lastBeat(lastBeat)
  );

  assert_desc_word_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && (stb.addrSel inside {SEL_DSRC, SEL_DDST, SEL_DCTL})) |-> (memSize == SIZE_WORD));
  assert_hold_access_R14: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memAddr) && $stable(memWrite)));
endmodule

// File: tb/tb_dma_engine.sv
module tb_dma_engine;
  localparam int NCH = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN;
  logic [NCH-1:0] chReq, chSwStart, chDone;
  logic periphStall, memValid, memWrite, memReady, memError;
  logic [1:0] memSize;
  logic [31:0] memAddr, memWdata, memRdata;
  logic [0:0] activeCh;
  logic activeValid, busError;

  int checks = 0;
  int errors = 0;

  dma_engine #(.NUM_CH(NCH), .DESC_BASE(32'h0)) dut (
    .clk(clk), .rstN(rstN), .chReq(chReq), .chSwStart(chSwStart),
    .periphStall(periphStall), .memValid(memValid), .memWrite(memWrite),
    .memSize(memSize), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memReady(memReady), .memError(memError),
    .activeCh(activeCh), .activeValid(activeValid), .chDone(chDone),
    .busError(busError)
  );

  // bench memory model: 256 words, element in low bits of the data buses
  logic [31:0] mem [256] = '{default: 32'h0};
  logic bdWe = 1'b0;
  logic [7:0] bdIdx = '0;
  logic [31:0] bdData = '0;
  logic useWait = 1'b0, errArm = 1'b0;
  logic [31:0] errAddr = '0;
  logic [7:0] tick = '0;

  function automatic logic [31:0] mergeW(logic [31:0] old, logic [31:0] wd, logic [1:0] sz, logic [1:0] off);
    logic [31:0] r = old;
    int o = int'(off);
    case (sz)
      2'd0:    r[o*8 +: 8] = wd[7:0];
      2'd1:    r[o*8 +: 16] = wd[15:0];
      default: r = wd;
    endcase
    return r;
  endfunction

  always @(posedge clk) begin
    tick <= tick + 8'd1;
    if (bdWe) mem[bdIdx] <= bdData;
    else if (memValid && memReady && memWrite && !memError)
      mem[memAddr[9:2]] <= mergeW(mem[memAddr[9:2]], memWdata, memSize, memAddr[1:0]);
  end

  logic [31:0] rdShift;
  always_comb begin
    rdShift = mem[memAddr[9:2]] >> (8 * memAddr[1:0]);
    case (memSize)
      2'd0:    memRdata = rdShift & 32'hFF;
      2'd1:    memRdata = rdShift & 32'hFFFF;
      default: memRdata = rdShift;
    endcase
  end
  assign memReady = !useWait || tick[0];
  assign memError = errArm && memValid && (memAddr == errAddr);

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: done pulses, grant order, descriptor access size, held accesses
  int doneCnt [NCH] = '{default: 0};
  logic [0:0] grantLog [64];
  int logIdx = 0;
  int dataAcc = 0;
  logic prevAV = 1'b0, prevHeld = 1'b0, prevW = 1'b0;
  logic [31:0] prevA = '0;
  always @(negedge clk) begin
    if (!rstN) begin
      prevAV = 1'b0; prevHeld = 1'b0;
    end else begin
      for (int c = 0; c < NCH; c++) if (chDone[c]) doneCnt[c]++;
      if (activeValid && !prevAV) begin grantLog[logIdx % 64] = activeCh; logIdx++; end
      prevAV = activeValid;
      if (memValid && memReady && memAddr < 32'h20)
        checkEq("R3 record access size", 32'(memSize), 32'd2);
      if (memValid && memReady && memAddr >= 32'h20) dataAcc++;
      if (prevHeld) begin
        checkEq("R14 held access valid", 32'(memValid), 32'd1);
        checkEq("R14 held access address", memAddr, prevA);
        checkEq("R14 held access direction", 32'(memWrite), 32'(prevW));
      end
      prevHeld = memValid && !memReady;
      prevA = memAddr; prevW = memWrite;
    end
  end

  function automatic logic [31:0] mkCtl(int ss, int ds, int si, int di, int b, int cnt);
    return {16'(cnt), 4'h0, 4'(b), 2'b00, 1'(di), 1'(si), 2'(ds), 2'(ss)};
  endfunction

  task automatic wrWord(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); bdWe = 1'b1; bdIdx = a[9:2]; bdData = d;
    @(negedge clk); bdWe = 1'b0;
  endtask

  task automatic setDesc(input int ch, input logic [31:0] s, input logic [31:0] d, input logic [31:0] c);
    wrWord(32'(ch * 16), s);
    wrWord(32'(ch * 16 + 4), d);
    wrWord(32'(ch * 16 + 8), c);
  endtask

  task automatic swPulse(input logic [NCH-1:0] m);
    @(negedge clk); chSwStart = m;
    @(negedge clk); chSwStart = '0;
  endtask

  task automatic waitIdle();
    int n = 0;
    int quiet = 0;
    bit seen = activeValid;
    while ((!seen || quiet < 3) && n < 3000) begin
      @(negedge clk); n++;
      if (activeValid) begin seen = 1; quiet = 0; end
      else if (seen) quiet++;
    end
    checkEq("R6 engine returns idle", 32'(n < 3000), 32'd1);
  endtask

  task automatic doReset();
    rstN = 1'b0; chReq = '0; chSwStart = '0; periphStall = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    int d0, li;
    logic [31:0] cBurst, cByte, cHalf, expDst;
    doReset();
    @(negedge clk);
    // reset state
    checkEq("R6 activeValid after reset", 32'(activeValid), 32'd0);
    checkEq("R7 chDone after reset", 32'(chDone), 32'd0);
    checkEq("R8 busError after reset", 32'(busError), 32'd0);
    checkEq("R14 memValid after reset", 32'(memValid), 32'd0);

    // T1: word memory copy on channel 1 from software start, burst of two, wait states
    cBurst = mkCtl(2, 2, 1, 1, 1, 3);
    setDesc(1, 32'h100, 32'h200, cBurst);
    for (int i = 0; i < 3; i++) wrWord(32'h100 + 32'(4 * i), 32'hCAFE_0000 + 32'(i));
    useWait = 1'b1;
    d0 = doneCnt[1];
    swPulse(2'b10);
    waitIdle();
    checkEq("R12 R1 first word copied", mem[8'h80], 32'hCAFE_0000);
    checkEq("R11 second word copied", mem[8'h81], 32'hCAFE_0001);
    checkEq("R11 burst stops after two", mem[8'h82], 32'h0);
    checkEq("R4 R11 count written back", mem[6], mkCtl(2, 2, 1, 1, 1, 1));
    checkEq("R13 source advanced by 8", mem[4], 32'h108);
    checkEq("R13 destination advanced by 8", mem[5], 32'h208);
    checkEq("R7 no done while count left", 32'(doneCnt[1] - d0), 32'd0);
    swPulse(2'b10);
    waitIdle();
    checkEq("R11 last element capped by count", mem[8'h82], 32'hCAFE_0002);
    checkEq("R4 count reaches zero", mem[6], mkCtl(2, 2, 1, 1, 1, 0));
    checkEq("R7 done pulse on ch1", 32'(doneCnt[1] - d0), 32'd1);
    useWait = 1'b0;

    // T2: byte peripheral-to-memory on channel 0, one element per request
    cByte = mkCtl(0, 0, 0, 1, 0, 3);
    setDesc(0, 32'h300, 32'h280, cByte);
    d0 = doneCnt[0];
    expDst = 32'h0;
    for (int k = 0; k < 3; k++) begin
      wrWord(32'h300, 32'hFFFF_FF00 | (32'h11 * 32'(k + 1)));
      @(negedge clk); chReq[0] = 1'b1;
      repeat (30) @(negedge clk);
      checkEq("R6 active while held", 32'(activeValid), 32'd1);
      checkEq("R6 active channel 0", 32'(activeCh), 32'd0);
      checkEq("R10 no write-back while request high", mem[2], mkCtl(0, 0, 0, 1, 0, 3 - k));
      chReq[0] = 1'b0;
      waitIdle();
      expDst[k*8 +: 8] = 8'h11 * 8'(k + 1);
      checkEq("R1 byte element landed", mem[8'hA0], expDst);
      checkEq("R4 byte count updated", mem[2], mkCtl(0, 0, 0, 1, 0, 2 - k));
      checkEq("R13 fixed source kept", mem[0], 32'h300);
      checkEq("R13 destination advanced by 1", mem[1], 32'h280 + 32'(k + 1));
    end
    checkEq("R7 done once for ch0", 32'(doneCnt[0] - d0), 32'd1);

    // T3: half-word memory-to-peripheral with stall overlapping request release
    cHalf = mkCtl(1, 1, 1, 0, 1, 2);
    setDesc(0, 32'h140, 32'h304, cHalf);
    wrWord(32'h140, 32'hBBBB_AAAA);
    wrWord(32'h304, 32'h0);
    d0 = doneCnt[0];
    @(negedge clk); periphStall = 1'b1; chReq[0] = 1'b1;
    repeat (2) @(negedge clk);
    chReq[0] = 1'b0;
    repeat (40) @(negedge clk);
    checkEq("R9 still active under stall", 32'(activeValid), 32'd1);
    checkEq("R9 no write-back under stall", mem[2], cHalf);
    checkEq("R1 half-words moved", mem[8'hC1], 32'h0000_BBBB);
    periphStall = 1'b0;
    waitIdle();
    checkEq("R9 write-back after stall", mem[2], mkCtl(1, 1, 1, 0, 1, 0));
    checkEq("R13 source advanced by 4", mem[0], 32'h144);
    checkEq("R13 fixed destination kept", mem[1], 32'h304);
    checkEq("R7 done after stall", 32'(doneCnt[0] - d0), 32'd1);

    // T4: both channels started in the same cycle
    setDesc(0, 32'h180, 32'h1C0, mkCtl(2, 2, 1, 1, 0, 1));
    setDesc(1, 32'h184, 32'h1C4, mkCtl(2, 2, 1, 1, 0, 1));
    wrWord(32'h180, 32'h1234_5678);
    wrWord(32'h184, 32'h9ABC_DEF0);
    li = logIdx;
    swPulse(2'b11);
    waitIdle();
    checkEq("R5 two grants", 32'(logIdx - li), 32'd2);
    checkEq("R5 channel 0 first", 32'(grantLog[li % 64]), 32'd0);
    checkEq("R5 channel 1 second", 32'(grantLog[(li + 1) % 64]), 32'd1);
    checkEq("R12 ch0 copy", mem[8'h70], 32'h1234_5678);
    checkEq("R12 ch1 copy", mem[8'h71], 32'h9ABC_DEF0);

    // T5: error response on the second destination write
    setDesc(0, 32'h1A0, 32'h1E0, mkCtl(2, 2, 1, 1, 1, 2));
    wrWord(32'h1A0, 32'h5555_0001);
    wrWord(32'h1A4, 32'h5555_0002);
    wrWord(32'h1E4, 32'h0);
    useWait = 1'b1; errArm = 1'b1; errAddr = 32'h1E4;
    swPulse(2'b01);
    waitIdle();
    checkEq("R8 busError set", 32'(busError), 32'd1);
    checkEq("R8 first element kept", mem[8'h78], 32'h5555_0001);
    checkEq("R8 failed write absent", mem[8'h79], 32'h0);
    checkEq("R8 no control write-back", mem[2], mkCtl(2, 2, 1, 1, 1, 2));
    checkEq("R8 no source write-back", mem[0], 32'h1A0);
    errArm = 1'b0; useWait = 1'b0;
    li = logIdx;
    swPulse(2'b01);
    repeat (20) @(negedge clk);
    checkEq("R8 halted channel ignores start", 32'(logIdx - li), 32'd0);
    checkEq("R8 busError sticky", 32'(busError), 32'd1);

    // T6: mismatched sizes rejected
    doReset();
    @(negedge clk);
    checkEq("R8 busError cleared by reset", 32'(busError), 32'd0);
    setDesc(1, 32'h1A8, 32'h1E8, mkCtl(2, 1, 1, 1, 0, 1));
    wrWord(32'h1A8, 32'h7777_7777);
    wrWord(32'h1E8, 32'h0);
    d0 = dataAcc;
    swPulse(2'b10);
    waitIdle();
    checkEq("R2 busError on size mismatch", 32'(busError), 32'd1);
    checkEq("R2 no element access", 32'(dataAcc - d0), 32'd0);
    checkEq("R2 destination untouched", mem[8'h7A], 32'h0);
    checkEq("R2 control not written back", mem[6], mkCtl(2, 1, 1, 1, 0, 1));
    li = logIdx;
    swPulse(2'b10);
    repeat (20) @(negedge clk);
    checkEq("R2 rejected channel halted", 32'(logIdx - li), 32'd0);

    finishRun();
  end
endmodule